// File: doc/BRIEF.md
# Triggered Circular Sample Capture Buffer

This block records a channel word on every clock while it is running, into a power-of-two-deep circular memory in which each new word takes the place of the oldest. Software or a debug controller selects a trigger-position mode and pulses an arm command. From the trigger-event input the block then picks the first trigger that is allowed to count. It keeps recording until the post-trigger share of the memory is filled, and then it freezes. The post-trigger share is large, half or small, depending on the mode. A fourth mode ignores the trigger and records until a stop command.

Once capture is done, the memory is read through a random-access port. The read side converts the wrapped write pointer into a time order, so address zero is always the oldest stored word. A status output gives the read address at which the trigger word sits, so a viewer can mark the trigger without any knowledge of the wrap point.

Top module: `trace_capture_buf`

## Requirements
- R1: After synchronous reset, `done_o` is 0, `running_o` is 0 and `trig_idx_o` is 0.
- R2: A pulse on `arm_i` latches `mode_i` and, on the following clock, gives `running_o`=1 and `done_o`=0. The first word written is the one on `din_i` at the next rising edge. After that, one word is written on every edge while running.
- R3: Mode codes and post-trigger counts P for depth D: 0 gives floor(D*12/100), 1 gives D/2, 2 gives floor(D*88/100), and 3 is continuous. The trigger word is the first of the P post-trigger words. `done_o` rises, and `running_o` falls, on the edge that writes the P-th of them.
- R4: In modes 0 to 2, `trig_i` is ignored on an edge where fewer than D-P words have been written since arming. It is accepted on the first edge where at least D-P words have been written.
- R5: After a triggered capture completes, the word at read address k is the k-th oldest of the D most recent written words. `rd_data_o` shows it one clock after `rd_addr_i` is presented.
- R6: After a triggered capture completes, `trig_idx_o` equals D-P, which is the read address of the trigger word.
- R7: In mode 3, `trig_i` has no effect. A `stop_i` pulse ends capture on that edge without writing, and sets `done_o`. The min(N, D) most recent of the N words written are then read out oldest first from address 0, and `trig_idx_o` is 0.
- R8: In modes 0 to 2, `stop_i` has no effect on the capture.
- R9: `done_o` and the stored words stay unchanged until the next arm. A new arm clears `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Start a new capture (one-cycle pulse) |
| stop_i | input | 1 | End a continuous-mode capture |
| trig_i | input | 1 | Trigger event from the detection logic |
| mode_i | input | 2 | Trigger-position mode, latched at arm |
| din_i | input | DW | Channel word sampled each running cycle |
| rd_addr_i | input | AW | Time-ordered read address (0 = oldest) |
| rd_data_o | output | DW | Stored word, one cycle after the address |
| running_o | output | 1 | Capture in progress |
| done_o | output | 1 | Capture complete, memory frozen |
| trig_idx_o | output | AW | Read address of the trigger word |

## Verification
The bench drives a trigger one word before the pre-trigger region is full and again exactly when it becomes full. A design with an off-by-one fill test would accept the early trigger, which moves the entire readout and the trigger index. It also watches the cycle before and the cycle of completion in each mode, to catch a post-trigger count that is one short or one long. Continuous captures are run both short of one full wrap and past it. This exposes a read side that unrolls from the write pointer before the memory has ever filled, or that forgets to do so after it has. A stop in a triggered mode and a trigger in continuous mode are both applied, and each must leave the capture untouched.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;

    typedef enum logic [1:0] {
        POS_PRE    = 2'd0,
        POS_CENTER = 2'd1,
        POS_POST   = 2'd2,
        POS_CONT   = 2'd3
    } pos_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

    // Number of post-trigger words (trigger word included) for a mode.
    function automatic int unsigned post_len(int unsigned depth, pos_mode_e m);
        case (m)
            POS_PRE:    return (depth * 12) / 100;
            POS_CENTER: return depth / 2;
            POS_POST:   return (depth * 88) / 100;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/cap_mem.sv
`timescale 1ns/1ps
module cap_mem #(
    parameter int DEPTH = 128,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
        rd_data <= store[rd_addr];
    end
endmodule

// File: rtl/cap_ctrl.sv
`timescale 1ns/1ps
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          stop,
    input  logic          trig,
    input  logic [1:0]    mode,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] trig_ptr,
    output logic          full,
    output logic          is_cont,
    output cap_state_e    state
);
    localparam logic [AW:0] P_PRE    = (AW+1)'(post_len(DEPTH, POS_PRE));
    localparam logic [AW:0] P_CENTER = (AW+1)'(post_len(DEPTH, POS_CENTER));
    localparam logic [AW:0] P_POST   = (AW+1)'(post_len(DEPTH, POS_POST));
    localparam logic [AW:0] D_FULL   = (AW+1)'(DEPTH);

    pos_mode_e   mode_q;
    logic [AW:0] wr_cnt;
    logic [AW:0] post_rem;
    logic [AW:0] post_n;
    logic [AW:0] pre_need;
    logic        stop_now;
    logic        trig_ok;

    always_comb begin
        case (mode_q)
            POS_PRE:    post_n = P_PRE;
            POS_CENTER: post_n = P_CENTER;
            POS_POST:   post_n = P_POST;
            default:    post_n = '0;
        endcase
        pre_need = D_FULL - post_n;
    end

    assign is_cont  = (mode_q == POS_CONT);
    assign stop_now = is_cont && stop;
    assign trig_ok  = !is_cont && trig && (wr_cnt >= pre_need);
    assign full     = (wr_cnt == D_FULL);
    assign wr_en    = !arm && (((state == ST_FILL) && !stop_now) || (state == ST_POST));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mode_q   <= POS_PRE;
            wr_ptr   <= '0;
            wr_cnt   <= '0;
            post_rem <= '0;
            trig_ptr <= '0;
        end else if (arm) begin
            state    <= ST_FILL;
            mode_q   <= pos_mode_e'(mode);
            wr_ptr   <= '0;
            wr_cnt   <= '0;
            post_rem <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
                if (!full) wr_cnt <= wr_cnt + 1'b1;
            end
            case (state)
                ST_FILL: begin
                    if (stop_now) begin
                        state <= ST_DONE;
                    end else if (trig_ok) begin
                        trig_ptr <= wr_ptr;
                        if (post_n <= 1) begin
                            state <= ST_DONE;
                        end else begin
                            state    <= ST_POST;
                            post_rem <= post_n - 1'b1;
                        end
                    end
                end
                ST_POST: begin
                    post_rem <= post_rem - 1'b1;
                    if (post_rem == 1) state <= ST_DONE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cap_unroll.sv
`timescale 1ns/1ps
module cap_unroll #(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0] wr_ptr,
    input  logic          full,
    input  logic [AW-1:0] trig_ptr,
    input  logic          is_cont,
    input  logic [AW-1:0] log_addr,
    output logic [AW-1:0] phys_addr,
    output logic [AW-1:0] trig_idx
);
    logic [AW-1:0] oldest;

    // Once wrapped, the next write slot holds the oldest word.
    assign oldest    = full ? wr_ptr : '0;
    assign phys_addr = oldest + log_addr;
    assign trig_idx  = is_cont ? '0 : (trig_ptr - oldest);
endmodule

// File: rtl/trace_capture_buf.sv
`timescale 1ns/1ps
module trace_capture_buf
    import cap_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_i,
    input  logic          stop_i,
    input  logic          trig_i,
    input  logic [1:0]    mode_i,
    input  logic [DW-1:0] din_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          running_o,
    output logic          done_o,
    output logic [AW-1:0] trig_idx_o
);
    cap_state_e    state;
    logic          wr_en;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] trig_ptr;
    logic [AW-1:0] phys_addr;
    logic          full;
    logic          is_cont;

    cap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .arm(arm_i), .stop(stop_i), .trig(trig_i),
        .mode(mode_i), .wr_en(wr_en), .wr_ptr(wr_ptr), .trig_ptr(trig_ptr),
        .full(full), .is_cont(is_cont), .state(state)
    );

    cap_unroll #(.DEPTH(DEPTH)) u_unroll (
        .wr_ptr(wr_ptr), .full(full), .trig_ptr(trig_ptr), .is_cont(is_cont),
        .log_addr(rd_addr_i), .phys_addr(phys_addr), .trig_idx(trig_idx_o)
    );

    cap_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_ptr), .wr_data(din_i),
        .rd_addr(phys_addr), .rd_data(rd_data_o)
    );

    assign running_o = (state == ST_FILL) || (state == ST_POST);
    assign done_o    = (state == ST_DONE);
endmodule

// File: rtl/cap_checker.sv
`timescale 1ns/1ps
module cap_checker #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          arm_i,
    input logic          running_o,
    input logic          done_o,
    input logic          wr_en,
    input logic [AW-1:0] trig_idx_o
);
    // R3
    done_vs_running_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && running_o));

    // R2
    arm_starts_chk: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (running_o && !done_o));

    // R9
    done_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !arm_i) |=> (done_o && $stable(trig_idx_o)));

    // R9
    frozen_mem_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !wr_en);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!running_o && !done_o) |-> !wr_en);
endmodule

bind trace_capture_buf cap_checker #(.AW(AW)) u_cap_chk (
    .clk(clk), .rst(rst), .arm_i(arm_i), .running_o(running_o),
    .done_o(done_o), .wr_en(wr_en), .trig_idx_o(trig_idx_o)
);

// File: tb/test_trace_capture_buf.sv
`timescale 1ns/1ps
module test_trace_capture_buf;
    localparam int D  = 128;
    localparam int DW = 16;
    localparam int AW = 7;

    logic          clk = 0, rst = 1, arm = 0, stop = 0, trig = 0;
    logic [1:0]    mode = 0;
    logic [DW-1:0] din = 0;
    logic [AW-1:0] rd_addr = 0;
    logic [DW-1:0] rd_data;
    logic          running, done;
    logic [AW-1:0] trig_idx;

    trace_capture_buf #(.DEPTH(D), .DW(DW)) i_trace_capture_buf (
        .clk(clk), .rst(rst), .arm_i(arm), .stop_i(stop), .trig_i(trig),
        .mode_i(mode), .din_i(din), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .running_o(running), .done_o(done), .trig_idx_o(trig_idx)
    );

    always #2 clk = ~clk;
    always @(posedge clk) din <= din + 1'b1;

    int n_chk = 0, n_err = 0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard for read data.
    typedef struct { string req; int exp; } item_t;
    item_t q[$];
    logic rd_req = 0, rd_pipe = 0;
    always @(posedge clk) rd_pipe <= rd_req;
    always @(negedge clk) begin
        item_t it;
        if (rd_pipe) begin
            if (q.size() == 0) begin
                check("scoreboard", 0, 1);
            end else begin
                it = q.pop_front();
                check(it.req, int'(rd_data), it.exp);
            end
        end
    end

    task automatic read_seq(int n, int first, string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rd_addr = AW'(k);
            rd_req  = 1;
            q.push_back('{req, (first + k) & 16'hFFFF});
        end
        @(negedge clk);
        rd_req = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_stamp(int s);
        while (int'(din) != s) @(negedge clk);
    endtask

    task automatic do_arm(logic [1:0] m, output int a);
        @(negedge clk);
        mode = m;
        arm  = 1;
        a    = int'(din);
        @(negedge clk);
        arm = 0;
        check("R2 running after arm", int'(running), 1);
        check("R9 done cleared by arm", int'(done), 0);
    endtask

    task automatic pulse_trig(int s);
        wait_stamp(s);
        trig = 1;
        @(negedge clk);
        trig = 0;
    endtask

    // Triggered capture; ign_off < 0 means no early trigger.
    task automatic run_trig(logic [1:0] m, int p, int ign_off, int off, bit with_stop);
        int a, t, pre;
        pre = D - p;
        do_arm(m, a);
        if (ign_off >= 0) begin
            pulse_trig(a + 1 + ign_off);
            check("R4 early trigger ignored", int'(running), 1);
        end
        t = a + 1 + off;
        pulse_trig(t);
        if (with_stop) begin
            wait_stamp(t + 2);
            stop = 1;
            @(negedge clk);
            stop = 0;
            check("R8 stop ignored, still running", int'(running), 1);
            check("R8 stop ignored, not done", int'(done), 0);
        end
        wait_stamp(t + p - 1);
        check("R3 not done before last post word", int'(done), 0);
        @(negedge clk);
        check("R3 done on last post word", int'(done), 1);
        check("R3 running low when done", int'(running), 0);
        check("R6 trigger index", int'(trig_idx), pre);
        read_seq(D, t - pre, "R5 readout");
        repeat (5) @(negedge clk);
        check("R9 done held", int'(done), 1);
        read_seq(1, t - pre, "R9 oldest word kept");
    endtask

    task automatic run_cont(int nw);
        int a, n;
        do_arm(2'd3, a);
        pulse_trig(a + 5);
        check("R7 trigger ignored in continuous", int'(done), 0);
        wait_stamp(a + 1 + nw);
        stop = 1;
        @(negedge clk);
        stop = 0;
        check("R7 stop sets done", int'(done), 1);
        check("R7 trigger index zero", int'(trig_idx), 0);
        n = (nw < D) ? nw : D;
        read_seq(n, a + 1 + nw - n, "R7 readout");
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 done after reset", int'(done), 0);
        check("R1 running after reset", int'(running), 0);
        check("R1 trig index after reset", int'(trig_idx), 0);

        // center: P = 64, pre = 64
        run_trig(2'd1, D / 2, -1, 100, 0);
        // pre: P = 15, pre = 113; trigger one word early, then later
        run_trig(2'd0, (D * 12) / 100, (D - (D * 12) / 100) - 1, 130, 0);
        // post: P = 112, pre = 16; trigger exactly at the boundary, stop ignored
        run_trig(2'd2, (D * 88) / 100, -1, D - (D * 88) / 100, 1);
        // continuous, short of a wrap and past it
        run_cont(40);
        run_cont(300);
        summary();
    end
endmodule